// File: doc/BRIEF.md
# Dual-Core Reset and Cache-Flush Sequencer

This block drives the clock enable and the active-high reset of two processor cores and carries a cache-flush handshake for each of them. Software reaches it through a plain register port. There is one 32-bit control word per core and one shared timing word. In a control word, the upper half holds one write-enable bit for each writable bit of the lower half. A written bit changes only when its enable bit, 16 places higher, is 1 in the same write.

Every reset change happens inside a window in which the core clock is stopped. The sequence is: gate the clock, wait a programmed interval, change reset, wait the interval again, then ungate. The interval is counted in ticks that a prescaler derives from the system clock (0.25 µs per tick by intent, `CLK_PER_TICK` cycles each). Each core has a 4-bit interval, so each wait lasts 0 to 15 ticks.

Core 0 uses a one-shot style. Setting its reset bit runs apply-then-remove and clears the bit again. Core 1 uses a level style: reset stays applied while software holds the bit at 1. Both styles raise a sticky done flag once reset has been removed. Software clears that flag by writing 1 to it.

Each core runs one sequencer state machine:
- States: `S_IDLE` (clock on, reset off), `S_PRE_APPLY` (clock off, reset off), `S_POST_APPLY` (clock off, reset on), `S_HELD` (clock on, reset on; core 1 only), `S_PRE_REMOVE` (clock off, reset on), `S_POST_REMOVE` (clock off, reset off).
- Transitions: `S_IDLE`→`S_PRE_APPLY` when the reset bit is 1. `S_PRE_APPLY`→`S_POST_APPLY` at the end of the interval. `S_POST_APPLY`→`S_POST_REMOVE` at the end of the interval for core 0, or →`S_HELD` for core 1. `S_HELD`→`S_PRE_REMOVE` when the bit is 0. `S_PRE_REMOVE`→`S_POST_REMOVE` at the end of the interval. `S_POST_REMOVE`→`S_IDLE` at the end of the interval, which sets done and, for core 0, clears the reset bit.

Top module: `cpurst_ctrl`

## Requirements
- R1: A write to a core control word changes bit n (n = 0, 4 or 12) only when bit n+16 of the same write data is 1; otherwise that bit keeps its value.
- R2: Control word layout: bit 0 is the reset request, bit 4 is the flush request and bit 12 is the done flag. The enables are bits 16, 20 and 28. All other bits read as 0. Address 0 selects core 0, address 1 selects core 1 and address 2 selects the timing word.
- R3: The done flag is cleared only by a write with both bit 12 and bit 28 set to 1; a write with bit 12 set but bit 28 clear leaves it set.
- R4: For core 0, writing 1 to the reset bit runs a full apply-and-remove sequence. At its end the reset bit reads 0 and the done flag reads 1. Core 0 reset is never high while its clock is enabled.
- R5: For core 1, reset stays applied with the clock running while the reset bit is 1. After software writes the bit to 0, reset is removed and the done flag sets.
- R6: The timing word holds the core 0 interval in bits [3:0] and the core 1 interval in bits [7:4]. Each wait in a sequence lasts that many prescaler ticks (0 to 15), and an interval of 0 gives a one-cycle wait.
- R7: A core's reset output changes only in a cycle in which that core's clock enable was low in the previous cycle and is low in the current one.
- R8: A flush request bit drives the core's flush request output and stays set until that core's acknowledge input is seen. Hardware then clears it. Requests written while one is pending, writes of 0, and acknowledges while no request is pending all have no effect, and a flush never sets done.
- R9: After reset, every register reads 0, both clock enables are high, and both reset and flush outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (core words, then timing word) |
| reg_wdata | input | 32 | Write data with enable bits in the upper half |
| reg_rdata | output | 32 | Read data for the addressed register |
| core_clk_en | output | 2 | Clock enable per core, high means running |
| core_rst | output | 2 | Active-high reset per core |
| flush_req | output | 2 | Cache flush request per core |
| flush_ack | input | 2 | Cache flush completion pulse per core |

## Verification
On every cycle the assertions check these rules:
- A reset edge occurs only inside a clock-stopped window.
- Core 0 never holds reset with its clock running.
- Done rises only as a clock comes back with reset removed.
- Core 0's reset bit falls only together with done rising.
- A flush request holds until it is acknowledged and drops right after the acknowledge.

Only the bench scenarios can show the following:
- The write-enable masking and the register layout.
- The length of the gated window for intervals of 0, 2 and 15.
- The level-held behaviour of core 1.
- That extra flush writes and stray acknowledges are ignored.

// File: rtl/cpurst_pkg.sv
package cpurst_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE_APPLY,
        S_POST_APPLY,
        S_HELD,
        S_PRE_REMOVE,
        S_POST_REMOVE
    } seq_state_t;

    localparam int unsigned RST_BIT   = 0;
    localparam int unsigned FLUSH_BIT = 4;
    localparam int unsigned DONE_BIT  = 12;
    localparam int unsigned WEN_SHIFT = 16;
endpackage

// File: rtl/cpurst_tick.sv
module cpurst_tick #(
    parameter int unsigned CLK_PER_TICK = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/cpurst_flush.sv
module cpurst_flush (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic ack,
    output logic pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             pend <= 1'b0;
        else if (pend && ack)   pend <= 1'b0;
        else if (set_req)       pend <= 1'b1;
    end
endmodule

// File: rtl/cpurst_seq.sv
module cpurst_seq
    import cpurst_pkg::*;
#(
    parameter bit          SELF_CLEAR = 1'b1,
    parameter int unsigned IVAL_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [IVAL_W-1:0] ival,
    input  logic              req_wr,
    input  logic              req_val,
    input  logic              done_clr,
    output logic              req_q,
    output logic              done_q,
    output logic              clk_en,
    output logic              core_rst
);
    seq_state_t        state, nxt;
    logic [IVAL_W-1:0] cnt;
    logic              phase_end;
    logic              finish;
    logic              waiting;

    assign phase_end = (cnt >= ival);
    assign finish    = (state == S_POST_REMOVE) && phase_end;
    assign waiting   = (state != S_IDLE) && (state != S_HELD);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:        if (req_q)     nxt = S_PRE_APPLY;
            S_PRE_APPLY:   if (phase_end) nxt = S_POST_APPLY;
            S_POST_APPLY:  if (phase_end) nxt = SELF_CLEAR ? S_POST_REMOVE : S_HELD;
            S_HELD:        if (!req_q)    nxt = S_PRE_REMOVE;
            S_PRE_REMOVE:  if (phase_end) nxt = S_POST_REMOVE;
            S_POST_REMOVE: if (phase_end) nxt = S_IDLE;
            default:                      nxt = S_IDLE;
        endcase
    end

    // state register, interval counter and control bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            req_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt != state || !waiting)  cnt <= '0;
            else if (tick && !phase_end)   cnt <= cnt + 1'b1;

            if (SELF_CLEAR) begin
                if (finish)                  req_q <= 1'b0;
                else if (req_wr && req_val)  req_q <= 1'b1;
            end else if (req_wr) begin
                req_q <= req_val;
            end

            if (finish)        done_q <= 1'b1;
            else if (done_clr) done_q <= 1'b0;
        end
    end

    // outputs decoded from state
    always_comb begin
        clk_en   = 1'b1;
        core_rst = 1'b0;
        unique case (state)
            S_IDLE:        begin clk_en = 1'b1; core_rst = 1'b0; end
            S_PRE_APPLY:   begin clk_en = 1'b0; core_rst = 1'b0; end
            S_POST_APPLY:  begin clk_en = 1'b0; core_rst = 1'b1; end
            S_HELD:        begin clk_en = 1'b1; core_rst = 1'b1; end
            S_PRE_REMOVE:  begin clk_en = 1'b0; core_rst = 1'b1; end
            S_POST_REMOVE: begin clk_en = 1'b0; core_rst = 1'b0; end
            default:       begin clk_en = 1'b1; core_rst = 1'b0; end
        endcase
    end
endmodule

// File: rtl/cpurst_ctrl.sv
module cpurst_ctrl
    import cpurst_pkg::*;
#(
    parameter int unsigned NCORE        = 2,
    parameter int unsigned CLK_PER_TICK = 12,
    parameter int unsigned IVAL_W       = 4,
    localparam int unsigned ADDR_W      = $clog2(NCORE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NCORE-1:0]  core_clk_en,
    output logic [NCORE-1:0]  core_rst,
    output logic [NCORE-1:0]  flush_req,
    input  logic [NCORE-1:0]  flush_ack
);
    localparam int unsigned TIM_W = NCORE * IVAL_W;
    localparam logic [ADDR_W-1:0] TIM_ADDR = ADDR_W'(NCORE);

    logic             tick;
    logic [TIM_W-1:0] tim_q;
    logic [NCORE-1:0] req_bits;
    logic [NCORE-1:0] done_bits;

    cpurst_tick #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              tim_q <= '0;
        else if (reg_we && reg_addr == TIM_ADDR) tim_q <= reg_wdata[TIM_W-1:0];
    end

    for (genvar g = 0; g < NCORE; g++) begin : g_core
        logic sel;
        assign sel = reg_we && (reg_addr == ADDR_W'(g));

        cpurst_seq #(
            .SELF_CLEAR(g == 0),
            .IVAL_W    (IVAL_W)
        ) u_seq (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .ival    (tim_q[g*IVAL_W +: IVAL_W]),
            .req_wr  (sel && reg_wdata[RST_BIT + WEN_SHIFT]),
            .req_val (reg_wdata[RST_BIT]),
            .done_clr(sel && reg_wdata[DONE_BIT + WEN_SHIFT] && reg_wdata[DONE_BIT]),
            .req_q   (req_bits[g]),
            .done_q  (done_bits[g]),
            .clk_en  (core_clk_en[g]),
            .core_rst(core_rst[g])
        );

        cpurst_flush u_flush (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_req(sel && reg_wdata[FLUSH_BIT + WEN_SHIFT] && reg_wdata[FLUSH_BIT]),
            .ack    (flush_ack[g]),
            .pend   (flush_req[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == TIM_ADDR) reg_rdata[TIM_W-1:0] = tim_q;
        for (int i = 0; i < NCORE; i++) begin
            if (reg_addr == ADDR_W'(i)) begin
                reg_rdata[RST_BIT]   = req_bits[i];
                reg_rdata[FLUSH_BIT] = flush_req[i];
                reg_rdata[DONE_BIT]  = done_bits[i];
            end
        end
    end
endmodule

// File: rtl/cpurst_ctrl_chk.sv
module cpurst_ctrl_chk #(
    parameter int unsigned NCORE = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCORE-1:0] core_clk_en,
    input logic [NCORE-1:0] core_rst,
    input logic [NCORE-1:0] flush_req,
    input logic [NCORE-1:0] flush_ack,
    input logic [NCORE-1:0] req_q,
    input logic [NCORE-1:0] done_q
);
    for (genvar g = 0; g < NCORE; g++) begin : g_chk
        p_rst_edge_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (core_rst[g] != $past(core_rst[g])) |-> (!core_clk_en[g] && !$past(core_clk_en[g])));

        p_done_at_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(done_q[g]) |-> (core_clk_en[g] && !core_rst[g]));

        p_flush_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (flush_req[g] && !flush_ack[g]) |=> flush_req[g]);

        p_flush_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (flush_req[g] && flush_ack[g]) |=> !flush_req[g]);
    end

    p_selfclear_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_q[0]) |-> done_q[0]);

    p_core0_not_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst[0] |-> !core_clk_en[0]);
endmodule

bind cpurst_ctrl cpurst_ctrl_chk #(.NCORE(NCORE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_clk_en(core_clk_en),
    .core_rst   (core_rst),
    .flush_req  (flush_req),
    .flush_ack  (flush_ack),
    .req_q      (req_bits),
    .done_q     (done_bits)
);

// File: tb/cpurst_ctrl_test.sv
module cpurst_ctrl_test;
    localparam int unsigned DIV = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  core_clk_en, core_rst, flush_req;
    logic [1:0]  flush_ack = '0;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    cpurst_ctrl #(.NCORE(2), .CLK_PER_TICK(DIV), .IVAL_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_clk_en(core_clk_en),
        .core_rst(core_rst), .flush_req(flush_req), .flush_ack(flush_ack)
    );

    // {addr, write data, expected readback of the same address}
    localparam logic [65:0] VEC [6] = '{
        {2'd1, 32'h0000_0011, 32'h0000_0000},  // R1 no enables
        {2'd1, 32'h0001_0001, 32'h0000_0001},  // R5 level set, R2 layout
        {2'd1, 32'h0000_0000, 32'h0000_0001},  // R1 unmasked clear ignored
        {2'd2, 32'h0000_00A3, 32'h0000_00A3},  // R6 timing word
        {2'd0, 32'h0010_0010, 32'h0000_0010},  // R8 flush request, R2 bit 4
        {2'd1, 32'h0001_0000, 32'h0000_0000}   // R5 level released
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_ack(input logic [1:0] m);
        @(negedge clk);
        flush_ack = m;
        @(negedge clk);
        flush_ack = '0;
    endtask

    task automatic run_core0(input int n);
        int gated = 0;
        bit saw_rst = 0;
        bit bad = 0;
        bit opened = 0;
        logic [31:0] d;
        wr(2'd2, 32'(n));
        wr(2'd0, 32'h0001_0001);
        for (int c = 0; c < 5000; c++) begin
            @(negedge clk);
            if (core_rst[0] && core_clk_en[0]) bad = 1;
            if (core_rst[0]) saw_rst = 1;
            if (!core_clk_en[0]) begin gated++; opened = 1; end
            else if (opened) break;
        end
        rd(2'd0, d);
        check("R4 core0 self-clear and done", d, 32'h0000_1000);
        check("R7 reset only inside gated window", {30'd0, saw_rst, bad}, 32'h2);
        if (n == 0)
            check("R6 zero interval gated cycles", 32'(gated), 32'd3);
        else
            check("R6 gated cycles within interval bounds",
                  32'((gated >= 3*(n-1)*DIV) && (gated <= 3*(n*DIV+2))), 32'd1);
        wr(2'd0, 32'h1000_1000);
        rd(2'd0, d);
        check("R3 masked W1C clears done", d, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        rd(2'd0, d); check("R9 core0 word", d, 32'h0);
        rd(2'd1, d); check("R9 core1 word", d, 32'h0);
        rd(2'd2, d); check("R9 timing word", d, 32'h0);
        check("R9 outputs", {26'd0, core_clk_en, core_rst, flush_req}, {26'd0, 2'b11, 2'b00, 2'b00});

        // table walk
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][65:64], VEC[i][63:32]);
            rd(VEC[i][65:64], d);
            check($sformatf("R1/R2 vector %0d", i), d, VEC[i][31:0]);
        end

        // R5 core1 release completes with done
        ok = 0;
        for (int c = 0; c < 3000; c++) begin
            rd(2'd1, d);
            if (d[12]) begin ok = 1; break; end
        end
        check("R5 core1 done after release", d, 32'h0000_1000);
        check("R5 core1 outputs after release", {30'd0, core_rst[1], core_clk_en[1]}, 32'h1);

        // R3 clear needs enable
        wr(2'd1, 32'h0000_1000);
        rd(2'd1, d); check("R3 unmasked W1C ignored", d, 32'h0000_1000);
        wr(2'd1, 32'h1000_1000);
        rd(2'd1, d); check("R3 masked W1C clears", d, 32'h0);

        // R8 flush handshake on core0 (requested by the table)
        check("R8 flush pending", {30'd0, flush_req}, 32'h1);
        pulse_ack(2'b10);
        check("R8 other core ack ignored", {30'd0, flush_req}, 32'h1);
        wr(2'd0, 32'h0010_0010);
        wr(2'd0, 32'h0010_0000);
        check("R8 writes while pending ignored", {30'd0, flush_req}, 32'h1);
        pulse_ack(2'b01);
        check("R8 ack clears flush", {30'd0, flush_req}, 32'h0);
        rd(2'd0, d); check("R8 flush leaves no done", d, 32'h0);
        pulse_ack(2'b01);
        check("R8 idle ack ignored", {30'd0, flush_req}, 32'h0);

        // R1 core0 reset without enable does nothing
        wr(2'd0, 32'h0000_0001);
        ok = 1;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (!core_clk_en[0] || core_rst[0]) ok = 0;
        end
        rd(2'd0, d);
        check("R1 core0 reset unmasked ignored", {d[31:1], ok}, 32'h1);

        // R4 / R6 / R7 core0 sequences
        run_core0(2);
        run_core0(0);
        run_core0(15);

        // R5 core1 level held
        wr(2'd2, 32'h0000_0010);
        wr(2'd1, 32'h0001_0001);
        repeat (300) @(negedge clk);
        check("R5 core1 held in reset with clock", {30'd0, core_rst[1], core_clk_en[1]}, 32'h3);
        rd(2'd1, d); check("R5 no done while held", d, 32'h1);
        wr(2'd1, 32'h0001_0000);
        for (int c = 0; c < 500; c++) begin
            rd(2'd1, d);
            if (d[12]) break;
        end
        check("R5 done after held release", d, 32'h0000_1000);
        check("R5 reset removed", {31'd0, core_rst[1]}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule